// File: doc/BRIEF.md
# Periodic Timer Time Base with Repetition Divider

This block is the time base of a general-purpose timer. A programmable prescaler divides the input clock by a ratio of (divider + 1). Each prescaler tick advances a 16-bit up-counter. The counter runs from zero to a programmed terminal value, and on reaching it wraps back to zero. A one-cycle wrap strobe marks every wrap.

A repetition stage thins the wraps into update events. An update is raised only when the repetition down-counter is already at zero as a wrap arrives. So with divider D, terminal value P and repetition count R, updates fall every (D+1)(P+1)(R+1) input clocks.

Software programs the block through a single-cycle write port that selects one of four registers. A write to the divider lands in a preload copy and reaches the prescaler only at the next update, so a ratio change never splits a period. A dedicated update-request input forces an update at once, restarting the whole chain from a clean state.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter reads 0, both strobes are low, and the divider, terminal value and repetition registers are 0; with the terminal value at 0 the counter stays at 0.
- R2: With active divider D and a terminal value above the count, the counter advances by one every D+1 input clocks, starting from the update that cleared it.
- R3: While the terminal value register is 0 the counter holds its value and no wrap strobe is produced.
- R4: The counter steps 0, 1, ..., P (P = terminal value) and then returns to 0; the wrap strobe is high for exactly the one cycle in which the counter first reads 0 after the wrap.
- R5: An update pulse follows a wrap only when the repetition down-counter was 0; otherwise the down-counter decrements. Consecutive updates are spaced (D+1)(P+1)(R+1) input clocks apart.
- R6: A divider write (wr_sel = 1) changes only the preload copy; the division ratio in use changes at the next update, not before.
- R7: A one-cycle pulse on upd_req produces an update pulse in the next cycle with the counter at 0. It restarts the prescaler and reloads the repetition down-counter and the active divider.
- R8: A write with wr_sel = 0 loads wr_data into the counter on the next clock edge, taking precedence over counting; counting resumes from the written value. Write selects: 0 counter, 1 divider, 2 terminal value, 3 repetition count.
- R9: Between two updates the wrap strobe pulses exactly R+1 times, the last one coinciding with the update pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 counter, 1 divider, 2 terminal value, 3 repetition |
| wr_data | input | 16 | Write data |
| upd_req | input | 1 | Software update request, one-cycle pulse |
| cnt_o | output | 16 | Current counter value |
| wrap_o | output | 1 | Counter wrap strobe |
| upd_o | output | 1 | Update event strobe |

## Verification
The assertions take for granted that upd_req and wr_en are single-cycle pulses and that the counter is never written with a value above a nonzero terminal value. Under those assumptions the step check and the wrap check describe every counter move. The stimulus keeps within this envelope. Every counter write is below the terminal value in force, and random settings draw terminal values from a small nonzero range. Updates are only requested from idle cycles, never in the cycle of a register write.

// File: rtl/tmrb_pkg.sv
// Shared definitions for the timer time base.
// Assumes a fixed 2-bit register select on the write port.
package tmrb_pkg;
    typedef enum logic [1:0] {
        SEL_CNT = 2'd0,
        SEL_DIV = 2'd1,
        SEL_PER = 2'd2,
        SEL_REP = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmrb_prescaler.sv
// Clock prescaler with a preloaded divider.
// Emits tick once every (div_act+1) clocks. The divider written by software
// sits in a preload register until an update event copies it into use;
// the same event restarts the prescale count at zero.
// Assumes upd_now is a combinational event for the current cycle.
module tmrb_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         div_wr,
    input  logic [W-1:0] div_data,
    input  logic         upd_now,
    output logic         tick
);
    logic [W-1:0] div_pre;
    logic [W-1:0] div_act;
    logic [W-1:0] pcnt;

    // tick when the prescale count has reached the active divider
    assign tick = (pcnt == div_act);

    // preload register captures software writes
    always_ff @(posedge clk) begin
        if (!rst_n)      div_pre <= '0;
        else if (div_wr) div_pre <= div_data;
    end

    // active divider follows the preload only at an update
    always_ff @(posedge clk) begin
        if (!rst_n)       div_act <= '0;
        else if (upd_now) div_act <= div_pre;
    end

    // prescale count: restart at update or tick, else advance
    always_ff @(posedge clk) begin
        if (!rst_n)              pcnt <= '0;
        else if (upd_now || tick) pcnt <= '0;
        else                     pcnt <= pcnt + 1'b1;
    end

    // R6: the ratio in use never moves without an update
    p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_now |=> $stable(div_act));

    // R7: an update leaves the prescale count at zero
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_now |=> (pcnt == '0));
endmodule

// File: rtl/tmrb_counter.sv
// Up-counter with a terminal value register.
// Advances on each prescaler tick from 0 to per_q, then wraps to 0.
// A terminal value of 0 freezes the counter. Software writes and update
// requests take precedence over counting.
// Assumes written counter values do not exceed a nonzero terminal value.
module tmrb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ug,
    input  logic         cnt_wr,
    input  logic         per_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         ovf_now,
    output logic         ovf_q
);
    logic [W-1:0] per_q;
    logic         run;

    // counting is allowed on a tick with a nonzero terminal value and no override
    assign run     = tick && (per_q != '0) && !cnt_wr && !ug;
    // a wrap happens when running at or beyond the terminal value
    assign ovf_now = run && (cnt_q >= per_q);

    // terminal value register, written directly
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '0;
        else if (per_wr) per_q <= wr_data;
    end

    // counter: update clears, write loads, otherwise count or wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ug)      cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= wr_data;
        else if (ovf_now) cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + 1'b1;
    end

    // registered wrap strobe, aligned with the counter reading 0
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_now;
    end

    // R3: zero terminal value freezes the counter
    p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0 && !cnt_wr && !ug) |=> $stable(cnt_q));

    // R4: the wrap strobe always shows the counter at zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));

    // R2: a tick below the terminal value steps by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ovf_now) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8: a counter write lands on the next edge
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ug) |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/tmrb_repeat.sv
// Repetition stage: turns counter wraps into update events.
// A wrap with the down-counter at zero raises an update and reloads the
// down-counter from the repetition register; any other wrap decrements it.
// A software request raises an update directly and also reloads.
module tmrb_repeat #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ovf_now,
    input  logic         ug,
    input  logic         rep_wr,
    input  logic [W-1:0] wr_data,
    output logic         upd_now,
    output logic         upd_q
);
    logic [W-1:0] rpr_q;
    logic [W-1:0] rep_cnt;
    logic         rep_zero;

    assign rep_zero = (rep_cnt == '0);
    // update on request, or on a wrap once repetitions are used up
    assign upd_now  = ug || (ovf_now && rep_zero);

    // repetition register, read on each reload
    always_ff @(posedge clk) begin
        if (!rst_n)      rpr_q <= '0;
        else if (rep_wr) rpr_q <= wr_data;
    end

    // down-counter: reload on update, decrement on other wraps
    always_ff @(posedge clk) begin
        if (!rst_n)       rep_cnt <= '0;
        else if (upd_now) rep_cnt <= rpr_q;
        else if (ovf_now) rep_cnt <= rep_cnt - 1'b1;
    end

    // registered update strobe, aligned with the counter outputs
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= upd_now;
    end

    // R5: a wrap with repetitions left raises no update
    p_no_early_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_now && !rep_zero && !ug) |=> !upd_q);

    // R7: a request reloads the down-counter from the register
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (rep_cnt == $past(rpr_q)));
endmodule

// File: rtl/tmr_timebase.sv
// Timer time base top: prescaler, counter and repetition stage.
// Decodes the single-cycle write port into per-register strokes and routes
// the update event back to the prescaler. All outputs are registered.
// Assumes wr_en and upd_req are single-cycle pulses.
module tmr_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         upd_req,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic         upd_o
);
    import tmrb_pkg::*;

    reg_sel_e sel;
    logic     cnt_wr, div_wr, per_wr, rep_wr;
    logic     tick, ovf_now, upd_now;

    // write decode into one stroke per register
    always_comb begin
        sel    = reg_sel_e'(wr_sel);
        cnt_wr = wr_en && (sel == SEL_CNT);
        div_wr = wr_en && (sel == SEL_DIV);
        per_wr = wr_en && (sel == SEL_PER);
        rep_wr = wr_en && (sel == SEL_REP);
    end

    tmrb_prescaler #(.W(W)) u_psc (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_data(wr_data),
        .upd_now(upd_now), .tick(tick)
    );

    tmrb_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ug(upd_req),
        .cnt_wr(cnt_wr), .per_wr(per_wr), .wr_data(wr_data),
        .cnt_q(cnt_o), .ovf_now(ovf_now), .ovf_q(wrap_o)
    );

    tmrb_repeat #(.W(W)) u_rep (
        .clk(clk), .rst_n(rst_n), .ovf_now(ovf_now), .ug(upd_req),
        .rep_wr(rep_wr), .wr_data(wr_data),
        .upd_now(upd_now), .upd_q(upd_o)
    );

    // R7: a request shows as an update with a cleared counter
    p_req_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> (upd_o && cnt_o == '0));

    // R9: every update not caused by a request coincides with a wrap
    p_upd_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && !$past(upd_req)) |-> wrap_o);
endmodule

// File: tb/tmr_timebase_bench.sv
module tmr_timebase_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int GAP_LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         upd_req = 1'b0;
    logic [W-1:0] cnt_o;
    logic         wrap_o, upd_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_timebase #(.W(W)) u_tmr_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_req(upd_req),
        .cnt_o(cnt_o), .wrap_o(wrap_o), .upd_o(upd_o)
    );

    function automatic int exp_gap(int d, int p, int r);
        return (d + 1) * (p + 1) * (r + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // request an update; returns at the negedge where upd_o should be high
    task automatic req_upd();
        @(negedge clk);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    // count clocks and wraps up to and including the next update
    task automatic gap(output int n, output int nw);
        n = 0; nw = 0;
        do begin
            @(negedge clk);
            n++;
            if (wrap_o) nw++;
        end while (!upd_o && n < GAP_LIMIT);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, nw, held;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle with zero terminal value
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 wrap", int'(wrap_o), 0);
        check("R1 upd", int'(upd_o), 0);
        repeat (10) @(negedge clk);
        check("R1 cnt idle", int'(cnt_o), 0);

        // R2: rate of D=3 over a long period
        wr(1, 3); wr(2, 200); wr(3, 0);
        req_upd();
        check("R7 upd pulse", int'(upd_o), 1);
        check("R7 cnt clear", int'(cnt_o), 0);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            check("R2 rate", int'(cnt_o), k / 4);
        end

        // R7: update request mid-run clears and restarts
        req_upd();
        check("R7 mid upd", int'(upd_o), 1);
        check("R7 mid cnt", int'(cnt_o), 0);
        check("R7 mid wrap", int'(wrap_o), 0);

        // R3: zero terminal value freezes the counter
        repeat (30) @(negedge clk);
        wr(2, 0);
        held = int'(cnt_o);
        check("R3 nonzero start", int'(held != 0), 1);
        nw = 0;
        repeat (40) begin
            @(negedge clk);
            if (wrap_o) nw++;
        end
        check("R3 held", int'(cnt_o), held);
        check("R3 no wrap", nw, 0);

        // R8: counter write wins and counting resumes
        wr(1, 0); wr(2, 100);
        req_upd();
        repeat (5) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd50;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 loaded", int'(cnt_o), 50);
        @(negedge clk);
        check("R8 resumes", int'(cnt_o), 51);

        // R4: wrap sequence with P=4, D=0, R=0
        wr(2, 4);
        req_upd();
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check("R4 seq", int'(cnt_o), k % 5);
            check("R4 wrap", int'(wrap_o), int'(k % 5 == 0));
        end

        // R6: divider change waits for the next update
        wr(1, 2); wr(2, 3); wr(3, 0);
        req_upd();
        gap(n, nw);
        check("R6 first", n, 12);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            wr_en = (n == 5);
            wr_sel = 2'd1; wr_data = 16'd4;
        end while (!upd_o && n < GAP_LIMIT);
        wr_en = 1'b0;
        check("R6 old ratio kept", n, 12);
        gap(n, nw);
        check("R6 new ratio", n, 20);

        // R5 / R9: random settings
        for (int it = 0; it < 12; it++) begin
            int d, p, r;
            d = int'($urandom_range(0, 3));
            p = int'($urandom_range(1, 6));
            r = int'($urandom_range(0, 3));
            wr(1, d); wr(2, p); wr(3, r);
            req_upd();
            for (int g = 0; g < 2; g++) begin
                gap(n, nw);
                check("R5 spacing", n, exp_gap(d, p, r));
                check("R9 wraps", nw, r + 1);
                check("R9 wrap with upd", int'(wrap_o), 1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule